// File: doc/BRIEF.md
# Dual-Read Scalar Register File with Result Forwarding

This block is the scalar operand store of a processor core. It holds a parameterised set of wide registers, 256 of 64 bits by default. In every clock it accepts two read addresses and one result write. Two read ports are built from two identical one-read/one-write storage banks. Each result is written into both banks at the same address in the same cycle, so the two banks always hold the same data. Port A always reads bank 0 and port B always reads bank 1.

Reads are synchronous. A value comes out one cycle after its address is presented. Before the value is registered, a forwarding selector checks the result taps of the arithmetic pipeline and the write that is taking place in the same cycle. The newest matching value takes the place of the stored one. Issue logic marks a destination register as pending when it sends out an instruction. The mark is removed when the result is written. A read of a pending register that no forwarding source can supply raises a not-ready flag next to the operand, and the issue stage holds the dependent instruction until the flag is clear.

The block is a register file. It has no streaming data interface, so all pins are plain control and data signals with no back-pressure. The caller must keep every read address stable for one cycle if it needs the result. Every pin is sampled on each rising clock edge.

Top module: `scalar_regfile_2r1w`

## Requirements
- R1: A read has one cycle of latency. The operand outputs change only on the clock edge that samples the read address.
- R2: The two ports read independently. When both ports read the same register in the same cycle, they return identical values.
- R3: A write with `wr_en` high stores `wr_data` in both banks. Both ports return the value from the next cycle onward, until it is overwritten.
- R4: When a read address equals `wr_addr` while `wr_en` is high in the same cycle, that port returns the new `wr_data`, unless a tap also matches.
- R5: When a tap has its valid bit set and its destination equals a read address, that port returns the tap's data.
- R6: Forwarding priority is fixed. Tap 0 is the youngest and wins over higher-numbered taps. Any matching tap wins over the current write, and the current write wins over the stored value.
- R7: `iss_en` marks register `iss_dst` as pending from the next cycle. A read of a pending register with no forwarding match returns its not-ready flag as 1 together with the operand.
- R8: A write clears the pending mark of its register. If an issue and a write name the same register in the same cycle, the register stays pending.
- R9: When a read matches a valid tap or the current write, its not-ready flag is 0, even if the register is pending.
- R10: While reset is asserted, both operands read 0 and both not-ready flags are 0. Reset clears every pending mark, but it does not clear the stored register contents.
- R11: A tap whose valid bit is 0 has no effect on either port, whatever its destination and data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_a_addr | input | AW | Read address of port A (bank 0) |
| rd_b_addr | input | AW | Read address of port B (bank 1) |
| wr_en | input | 1 | Result write enable |
| wr_addr | input | AW | Register written this cycle |
| wr_data | input | DW | Data written this cycle |
| tap_vld | input | NTAP | Valid bit per pipeline tap; bit 0 is the youngest |
| tap_dst | input | NTAP*AW | Destination register per tap; tap i is in bits [i*AW +: AW] |
| tap_data | input | NTAP*DW | Result value per tap; tap i is in bits [i*DW +: DW] |
| iss_en | input | 1 | An instruction issues this cycle |
| iss_dst | input | AW | Destination register of the issuing instruction |
| op_a | output | DW | Operand from port A |
| op_b | output | DW | Operand from port B |
| op_a_busy | output | 1 | Not-ready flag for op_a |
| op_b_busy | output | 1 | Not-ready flag for op_b |

## Verification
The assertions check these properties on every cycle:
- The two ports agree whenever they read the same register.
- A same-cycle write reaches the operand when no tap matches.
- Tap 0 is selected whenever it matches.
- A pending bit is set after an issue and cleared after a write.
- No not-ready flag appears on a cycle with a write-through match.

Only the directed scenarios can show some behaviours:
- The full priority order among several taps and the write.
- That a tap without its valid bit is ignored.
- The issue-beats-write rule for a single register.
- That reset clears pending marks and leaves stored data in place.

// File: rtl/rf_pkg.sv
`timescale 1ns/1ps
package rf_pkg;
  // Where a forwarded operand came from in the current cycle.
  typedef enum logic [1:0] {
    SRC_STORE = 2'd0,
    SRC_WRITE = 2'd1,
    SRC_TAP   = 2'd2
  } rf_src_e;
endpackage

// File: rtl/rf_bank.sv
`timescale 1ns/1ps
// One storage copy: one synchronous read, one write per cycle.
// A read of the address being written returns the old contents;
// forwarding in rf_port covers that case.
module rf_bank #(
  parameter int NREG = 256,
  parameter int DW   = 64,
  parameter int AW   = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] cells [NREG];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
    rdata <= cells[raddr];
  end
endmodule

// File: rtl/rf_fwd_sel.sv
`timescale 1ns/1ps
// Picks the newest in-flight value for one read address.
module rf_fwd_sel
  import rf_pkg::*;
#(
  parameter int NTAP = 2,
  parameter int DW   = 64,
  parameter int AW   = 8
) (
  input  logic [AW-1:0]      raddr,
  input  logic               wr_en,
  input  logic [AW-1:0]      wr_addr,
  input  logic [DW-1:0]      wr_data,
  input  logic [NTAP-1:0]    tap_vld,
  input  logic [NTAP*AW-1:0] tap_dst,
  input  logic [NTAP*DW-1:0] tap_data,
  output logic               hit,
  output rf_src_e            src,
  output logic [DW-1:0]      data
);
  logic [NTAP-1:0] tap_match;

  genvar gi;
  generate
    for (gi = 0; gi < NTAP; gi++) begin : g_cmp
      assign tap_match[gi] = tap_vld[gi] && (tap_dst[gi*AW +: AW] == raddr);
    end
  endgenerate

  // The oldest source is considered first, so a younger match replaces it.
  always_comb begin
    hit  = 1'b0;
    src  = SRC_STORE;
    data = '0;
    if (wr_en && (wr_addr == raddr)) begin
      hit  = 1'b1;
      src  = SRC_WRITE;
      data = wr_data;
    end
    for (int i = NTAP - 1; i >= 0; i--) begin
      if (tap_match[i]) begin
        hit  = 1'b1;
        src  = SRC_TAP;
        data = tap_data[i*DW +: DW];
      end
    end
  end

  // R6: tap 0 is the youngest and always wins when it matches.
  always_comb begin
    if (tap_vld[0] && (tap_dst[AW-1:0] == raddr)) begin
      assert_youngest_tap_wins_R6: assert (data == tap_data[DW-1:0]);
    end
  end
endmodule

// File: rtl/rf_scoreboard.sv
`timescale 1ns/1ps
// One pending bit per register: set at issue, cleared at write.
module rf_scoreboard #(
  parameter int NREG = 256,
  parameter int AW   = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            set_en,
  input  logic [AW-1:0]   set_addr,
  input  logic            clr_en,
  input  logic [AW-1:0]   clr_addr,
  output logic [NREG-1:0] pend
);
  logic [NREG-1:0] pend_nxt;

  // The set is applied after the clear, so an issue in the same cycle wins.
  always_comb begin
    pend_nxt = pend;
    if (clr_en) pend_nxt[clr_addr] = 1'b0;
    if (set_en) pend_nxt[set_addr] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend <= '0;
    else        pend <= pend_nxt;
  end

  assert_issue_marks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |=> pend[$past(set_addr)]);

  assert_write_releases_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && !(set_en && (set_addr == clr_addr))) |=> !pend[$past(clr_addr)]);
endmodule

// File: rtl/rf_port.sv
`timescale 1ns/1ps
// One read port: forwarding select, registered result and not-ready flag.
module rf_port
  import rf_pkg::*;
#(
  parameter int NTAP = 2,
  parameter int DW   = 64,
  parameter int AW   = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [AW-1:0]      raddr,
  input  logic               pend_bit,
  input  logic               wr_en,
  input  logic [AW-1:0]      wr_addr,
  input  logic [DW-1:0]      wr_data,
  input  logic [NTAP-1:0]    tap_vld,
  input  logic [NTAP*AW-1:0] tap_dst,
  input  logic [NTAP*DW-1:0] tap_data,
  input  logic [DW-1:0]      bank_q,
  output logic [DW-1:0]      val,
  output logic               busy
);
  logic          fhit;
  rf_src_e       fsrc;
  logic [DW-1:0] fdata;
  logic          hit_q;
  logic [DW-1:0] data_q;
  logic          seen_q;

  rf_fwd_sel #(.NTAP(NTAP), .DW(DW), .AW(AW)) u_sel (
    .raddr    (raddr),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .tap_vld  (tap_vld),
    .tap_dst  (tap_dst),
    .tap_data (tap_data),
    .hit      (fhit),
    .src      (fsrc),
    .data     (fdata)
  );

  // Under reset the forwarded path is selected with a zero value.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_q  <= 1'b1;
      data_q <= '0;
      busy   <= 1'b0;
      seen_q <= 1'b0;
    end else begin
      hit_q  <= fhit;
      data_q <= fdata;
      busy   <= pend_bit && !fhit;
      seen_q <= 1'b1;
    end
  end

  assign val = hit_q ? data_q : bank_q;

  assert_write_through_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && $past(fsrc == SRC_WRITE)) |-> (val == $past(wr_data)));

  assert_match_not_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && $past(wr_en && (wr_addr == raddr))) |-> !busy);
endmodule

// File: rtl/scalar_regfile_2r1w.sv
`timescale 1ns/1ps
module scalar_regfile_2r1w #(
  parameter int NREG = 256,
  parameter int DW   = 64,
  parameter int NTAP = 2,
  parameter int AW   = $clog2(NREG)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [AW-1:0]      rd_a_addr,
  input  logic [AW-1:0]      rd_b_addr,
  input  logic               wr_en,
  input  logic [AW-1:0]      wr_addr,
  input  logic [DW-1:0]      wr_data,
  input  logic [NTAP-1:0]    tap_vld,
  input  logic [NTAP*AW-1:0] tap_dst,
  input  logic [NTAP*DW-1:0] tap_data,
  input  logic               iss_en,
  input  logic [AW-1:0]      iss_dst,
  output logic [DW-1:0]      op_a,
  output logic [DW-1:0]      op_b,
  output logic               op_a_busy,
  output logic               op_b_busy
);
  localparam int NPORT = 2;

  logic [AW-1:0]   raddr [NPORT];
  logic [DW-1:0]   bank_q [NPORT];
  logic [DW-1:0]   val_w [NPORT];
  logic            busy_w [NPORT];
  logic [NREG-1:0] pend;
  logic            seen_q;

  assign raddr[0] = rd_a_addr;
  assign raddr[1] = rd_b_addr;

  rf_scoreboard #(.NREG(NREG), .AW(AW)) u_sb (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_en   (iss_en),
    .set_addr (iss_dst),
    .clr_en   (wr_en),
    .clr_addr (wr_addr),
    .pend     (pend)
  );

  // One bank copy per read port; every write goes to all copies.
  genvar gp;
  generate
    for (gp = 0; gp < NPORT; gp++) begin : g_port
      rf_bank #(.NREG(NREG), .DW(DW), .AW(AW)) u_bank (
        .clk   (clk),
        .we    (wr_en),
        .waddr (wr_addr),
        .wdata (wr_data),
        .raddr (raddr[gp]),
        .rdata (bank_q[gp])
      );

      rf_port #(.NTAP(NTAP), .DW(DW), .AW(AW)) u_port (
        .clk      (clk),
        .rst_n    (rst_n),
        .raddr    (raddr[gp]),
        .pend_bit (pend[raddr[gp]]),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .tap_vld  (tap_vld),
        .tap_dst  (tap_dst),
        .tap_data (tap_data),
        .bank_q   (bank_q[gp]),
        .val      (val_w[gp]),
        .busy     (busy_w[gp])
      );
    end
  endgenerate

  assign op_a      = val_w[0];
  assign op_b      = val_w[1];
  assign op_a_busy = busy_w[0];
  assign op_b_busy = busy_w[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_q <= 1'b0;
    else        seen_q <= 1'b1;
  end

  // R2: the copies never diverge, so equal addresses give equal operands.
  assert_copies_agree_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && ($past(rd_a_addr) == $past(rd_b_addr)))
      |-> ((op_a === op_b) && (op_a_busy == op_b_busy)));

  assert_reset_quiet_R10: assert property (@(posedge clk)
    !rst_n |-> ((op_a == '0) && (op_b == '0) && !op_a_busy && !op_b_busy));
endmodule

// File: tb/sim_scalar_regfile_2r1w.sv
`timescale 1ns/1ps
module sim_scalar_regfile_2r1w;
  localparam int NREG = 256;
  localparam int DW   = 64;
  localparam int NTAP = 2;
  localparam int AW   = 8;
  localparam int NROW = 15;

  typedef struct packed {
    logic [7:0]  ra;
    logic [7:0]  rb;
    logic        we;
    logic [7:0]  wa;
    logic [63:0] wd;
    logic        t0v;
    logic [7:0]  t0d;
    logic [63:0] t0x;
    logic        t1v;
    logic [7:0]  t1d;
    logic [63:0] t1x;
    logic        iv;
    logic [7:0]  id;
    logic [63:0] ea;
    logic [63:0] eb;
    logic        ab;
    logic        bb;
    logic [3:0]  req;
  } row_t;

  // Expected values follow from the requirements; each row is checked one cycle after it is driven.
  localparam row_t TBL [NROW] = '{
    // R4: write-through on both ports
    '{8'd5, 8'd5, 1'b1, 8'd5, 64'h55, 1'b0, 8'd0, 64'h0, 1'b0, 8'd0, 64'h0, 1'b0, 8'd0, 64'h55, 64'h55, 1'b0, 1'b0, 4'd4},
    // R3: stored value on A, write-through on B
    '{8'd5, 8'd6, 1'b1, 8'd6, 64'h66, 1'b0, 8'd0, 64'h0, 1'b0, 8'd0, 64'h0, 1'b0, 8'd0, 64'h55, 64'h66, 1'b0, 1'b0, 4'd3},
    // R2: independent ports (the write to 7 is not read)
    '{8'd6, 8'd5, 1'b1, 8'd7, 64'h77, 1'b0, 8'd0, 64'h0, 1'b0, 8'd0, 64'h0, 1'b0, 8'd0, 64'h66, 64'h55, 1'b0, 1'b0, 4'd2},
    // R5: each tap feeds one port
    '{8'd5, 8'd6, 1'b0, 8'd0, 64'h0, 1'b1, 8'd5, 64'hA0, 1'b1, 8'd6, 64'hB1, 1'b0, 8'd0, 64'hA0, 64'hB1, 1'b0, 1'b0, 4'd5},
    // R6: tap 0 beats tap 1 and the write; reg 5 becomes C2
    '{8'd5, 8'd5, 1'b1, 8'd5, 64'hC2, 1'b1, 8'd5, 64'hA0, 1'b1, 8'd5, 64'hB1, 1'b0, 8'd0, 64'hA0, 64'hA0, 1'b0, 1'b0, 4'd6},
    // R6: tap 1 beats the write
    '{8'd5, 8'd6, 1'b1, 8'd5, 64'hC2, 1'b0, 8'd0, 64'h0, 1'b1, 8'd5, 64'hB1, 1'b0, 8'd0, 64'hB1, 64'h66, 1'b0, 1'b0, 4'd6},
    // R3: stored write visible on both ports
    '{8'd5, 8'd5, 1'b0, 8'd0, 64'h0, 1'b0, 8'd0, 64'h0, 1'b0, 8'd0, 64'h0, 1'b0, 8'd0, 64'hC2, 64'hC2, 1'b0, 1'b0, 4'd3},
    // R11: tap without valid bit is ignored
    '{8'd5, 8'd6, 1'b0, 8'd0, 64'h0, 1'b0, 8'd5, 64'hFF, 1'b0, 8'd6, 64'hEE, 1'b0, 8'd0, 64'hC2, 64'h66, 1'b0, 1'b0, 4'd11},
    // R7: issue to 7 takes effect only after the edge
    '{8'd5, 8'd6, 1'b0, 8'd0, 64'h0, 1'b0, 8'd0, 64'h0, 1'b0, 8'd0, 64'h0, 1'b1, 8'd7, 64'hC2, 64'h66, 1'b0, 1'b0, 4'd7},
    // R7: pending 7 raises the A flag
    '{8'd7, 8'd5, 1'b0, 8'd0, 64'h0, 1'b0, 8'd0, 64'h0, 1'b0, 8'd0, 64'h0, 1'b0, 8'd0, 64'h77, 64'hC2, 1'b1, 1'b0, 4'd7},
    // R9: tap match clears the flag
    '{8'd7, 8'd7, 1'b0, 8'd0, 64'h0, 1'b0, 8'd0, 64'h0, 1'b1, 8'd7, 64'hD7, 1'b0, 8'd0, 64'hD7, 64'hD7, 1'b0, 1'b0, 4'd9},
    // R9: write-through clears the flag; issue to 7 in the same cycle
    '{8'd7, 8'd7, 1'b1, 8'd7, 64'hE7, 1'b0, 8'd0, 64'h0, 1'b0, 8'd0, 64'h0, 1'b1, 8'd7, 64'hE7, 64'hE7, 1'b0, 1'b0, 4'd9},
    // R8: issue beat the write, 7 still pending
    '{8'd7, 8'd7, 1'b0, 8'd0, 64'h0, 1'b0, 8'd0, 64'h0, 1'b0, 8'd0, 64'h0, 1'b0, 8'd0, 64'hE7, 64'hE7, 1'b1, 1'b1, 4'd8},
    // R8: the write to 7 releases it
    '{8'd5, 8'd7, 1'b1, 8'd7, 64'hF7, 1'b0, 8'd0, 64'h0, 1'b0, 8'd0, 64'h0, 1'b0, 8'd0, 64'hC2, 64'hF7, 1'b0, 1'b0, 4'd8},
    // R8: released register reads ready
    '{8'd7, 8'd7, 1'b0, 8'd0, 64'h0, 1'b0, 8'd0, 64'h0, 1'b0, 8'd0, 64'h0, 1'b0, 8'd0, 64'hF7, 64'hF7, 1'b0, 1'b0, 4'd8}
  };

  logic               clk = 1'b0;
  logic               rst_n;
  logic [AW-1:0]      rd_a_addr, rd_b_addr, wr_addr, iss_dst;
  logic               wr_en, iss_en;
  logic [DW-1:0]      wr_data;
  logic [NTAP-1:0]    tap_vld;
  logic [NTAP*AW-1:0] tap_dst;
  logic [NTAP*DW-1:0] tap_data;
  logic [DW-1:0]      op_a, op_b;
  logic               op_a_busy, op_b_busy;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  scalar_regfile_2r1w #(.NREG(NREG), .DW(DW), .NTAP(NTAP)) u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_a_addr (rd_a_addr),
    .rd_b_addr (rd_b_addr),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .tap_vld   (tap_vld),
    .tap_dst   (tap_dst),
    .tap_data  (tap_data),
    .iss_en    (iss_en),
    .iss_dst   (iss_dst),
    .op_a      (op_a),
    .op_b      (op_b),
    .op_a_busy (op_a_busy),
    .op_b_busy (op_b_busy)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    tap_vld = '0; tap_dst = '0; tap_data = '0;
    iss_en = 1'b0; iss_dst = '0;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 4);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    rd_a_addr = '0; rd_b_addr = '0;
    idle();
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10: quiet outputs during reset
    chk("R10 reset op_a", op_a, 64'h0);
    chk("R10 reset op_b", op_b, 64'h0);
    chk("R10 reset flags", {62'd0, op_a_busy, op_b_busy}, 64'h0);
    rst_n = 1'b1;

    for (int i = 0; i < NROW; i++) begin
      rd_a_addr = TBL[i].ra;
      rd_b_addr = TBL[i].rb;
      wr_en     = TBL[i].we;
      wr_addr   = TBL[i].wa;
      wr_data   = TBL[i].wd;
      tap_vld   = {TBL[i].t1v, TBL[i].t0v};
      tap_dst   = {TBL[i].t1d, TBL[i].t0d};
      tap_data  = {TBL[i].t1x, TBL[i].t0x};
      iss_en    = TBL[i].iv;
      iss_dst   = TBL[i].id;
      step();
      chk($sformatf("row%0d R%0d op_a", i, TBL[i].req), op_a, TBL[i].ea);
      chk($sformatf("row%0d R%0d op_b", i, TBL[i].req), op_b, TBL[i].eb);
      chk($sformatf("row%0d R%0d flags", i, TBL[i].req),
          {62'd0, op_a_busy, op_b_busy}, {62'd0, TBL[i].ab, TBL[i].bb});
    end
    idle();

    // R1: the output holds until the edge after the address changes
    rd_a_addr = 8'd5; rd_b_addr = 8'd5;
    wr_en = 1'b1; wr_addr = 8'd3; wr_data = 64'h33;
    step();
    idle();
    rd_a_addr = 8'd3;
    #1;
    chk("R1 before edge op_a", op_a, 64'hC2);
    step();
    chk("R1 after edge op_a", op_a, 64'h33);

    // R7 then R10: a pending mark is cleared by reset; stored data survives
    iss_en = 1'b1; iss_dst = 8'd9;
    step();
    idle();
    rd_a_addr = 8'd9; rd_b_addr = 8'd3;
    step();
    chk("R7 pending 9 flag", {63'd0, op_a_busy}, 64'h1);
    rst_n = 1'b0;
    step();
    step();
    rst_n = 1'b1;
    step();
    chk("R10 pending cleared by reset", {63'd0, op_a_busy}, 64'h0);
    chk("R10 stored data kept op_b", op_b, 64'h33);

    finish_run();
  end
endmodule